// File: doc/BRIEF.md
# PCI Type 0 Configuration Header

This block holds the 64-byte Type 0 configuration header of a 32-bit PCI target. The bus-phase state machine already decodes a configuration access. It hands the block a dword index, the active-low byte enables and, for writes, the data and a one-cycle write strobe. The block returns the addressed dword on a read port. That port follows the index combinationally and has no added latency. A write takes effect at the next rising clock edge.

The identity values are fixed by parameters. These are the vendor, device, revision, class code, subsystem IDs, interrupt pin, minimum grant, maximum latency and the capability pointer. Software can change the Command register, the two error flags in Status, Latency Timer, Cache Line Size and Interrupt Line. There are three base-address slots, and each one can be present or absent. Each present slot has its own space type (memory or I/O) and its own power-of-two size. The block compares every incoming bus address against the programmed bases and raises one hit line per slot. The surrounding target logic uses these hit lines to claim transactions.

Top module: `pci_cfg_header`

## Requirements
- R1: After a synchronous reset, Command, both Status error flags, Latency Timer, Cache Line Size, Interrupt Line and every BAR base are zero, and all hit lines are low.
- R2: Index 0 reads {device, vendor}. Index 2 reads {class code, revision}. Index 11 reads {subsystem ID, subsystem vendor ID}. Index 13 reads the capability pointer in bits 7:0 with zeros above. Index 15 reads {max latency, min grant, interrupt pin, interrupt line}. Index 3 reads {8'h00, 8'h00, latency timer, cache line size}.
- R3: On a write, byte lane k (bits 8k+7:8k) changes only when be_n[k] is 0. A lane whose enable is 1 keeps its old value.
- R4: Only Command bits 0 (I/O enable), 1 (memory enable), 2, 6 and 8 can be written. All other Command bits read as 0.
- R5: ev_parity_err sets Status bit 15 (dword bit 31). ev_target_abort sets Status bit 11 (dword bit 27). A write to index 1 that has lane 3 enabled clears each flag whose data bit is 1. An event arriving in the same cycle as a clear wins. Status bit 4 (dword bit 20) reads 1 when the capability pointer is nonzero.
- R6: A present BAR stores only the address bits at and above its size. After all ones are written, it reads back the size mask ORed with the type bits. A memory BAR has bits 3:0 = 0000. An I/O BAR has bit 0 = 1 and bit 1 = 0.
- R7: An absent BAR reads as zero, ignores writes and never hits.
- R8: bar_hit[i] is high only when three conditions hold together: bus_is_io matches the slot's type, the address bits at and above the slot size equal its base, and the space is enabled.
- R9: A memory BAR hits only while Command bit 1 is set. An I/O BAR hits only while Command bit 0 is set.
- R10: Every unimplemented index reads zero, and writes to it change nothing. These indices are 7 to 10, 12, 14 and 16 to 63.
- R11: Read data reflects the current index and state in the same cycle. A write is visible on the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe, one cycle per dword |
| cfg_idx | input | 6 | Dword index within the 256-byte space |
| cfg_be_n | input | 4 | Active-low byte enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_idx |
| ev_parity_err | input | 1 | Parity error event, sets Status bit 15 |
| ev_target_abort | input | 1 | Target abort event, sets Status bit 11 |
| bus_addr | input | 32 | Address of the current bus transaction |
| bus_is_io | input | 1 | 1 for an I/O transaction, 0 for memory |
| bar_hit | output | 3 | Per-slot address hit |

## Verification
A damaged base register or size mask shows up in two places. Sizing reads return the wrong mask on the cycle after the write. The hit lines also go wrong in the same cycle an address is presented, so hit decode is checked against a bench model over random bases and addresses. A byte-lane merge fault shows up as a corrupted neighbouring byte on the very next read, so random lane patterns are replayed against a shadow copy. A Status flag that is stuck or fails to clear is visible in the dword-1 read one cycle after its event or clearing write. A leaky read multiplexer appears at once as nonzero data at an unimplemented index.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

    localparam int NUM_BAR_SLOTS = 3;
    localparam int LOG2_W        = 5;

    localparam logic [5:0] IDX_ID      = 6'd0;
    localparam logic [5:0] IDX_CMDSTAT = 6'd1;
    localparam logic [5:0] IDX_CLASS   = 6'd2;
    localparam logic [5:0] IDX_MISC    = 6'd3;
    localparam logic [5:0] IDX_BAR0    = 6'd4;
    localparam logic [5:0] IDX_BAR1    = 6'd5;
    localparam logic [5:0] IDX_BAR2    = 6'd6;
    localparam logic [5:0] IDX_SUBSYS  = 6'd11;
    localparam logic [5:0] IDX_CAP     = 6'd13;
    localparam logic [5:0] IDX_INTR    = 6'd15;

    localparam logic [15:0] CMD_WMASK    = 16'h0147;
    localparam int          CMD_IO_BIT   = 0;
    localparam int          CMD_MEM_BIT  = 1;
    localparam int          ST_PERR_BIT  = 15;
    localparam int          ST_TABRT_BIT = 11;
    localparam int          ST_CAP_BIT   = 4;

    typedef struct packed {
        logic        en;
        logic [5:0]  idx;
        logic [3:0]  be_n;
        logic [31:0] data;
    } cfg_wr_t;

    function automatic logic [31:0] lane_merge(input logic [31:0] old_v,
                                               input logic [31:0] new_v,
                                               input logic [3:0]  be_n);
        logic [31:0] r;
        for (int k = 0; k < 4; k++) begin
            r[8*k +: 8] = be_n[k] ? old_v[8*k +: 8] : new_v[8*k +: 8];
        end
        return r;
    endfunction

    function automatic logic [31:0] size_mask(input int log2);
        return ~((32'h1 << log2) - 32'h1);
    endfunction

endpackage

// File: rtl/cfg_cmd_stat.sv
module cfg_cmd_stat
    import cfg_hdr_pkg::*;
#(
    parameter bit HAS_CAP = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_hit,
    input  logic [3:0]  be_n,
    input  logic [31:0] wdata,
    input  logic        ev_parity_err,
    input  logic        ev_target_abort,
    output logic [31:0] rd_val,
    output logic        io_en,
    output logic        mem_en
);
    logic [15:0] cmd_q;
    logic        perr_q;
    logic        tabrt_q;
    logic [15:0] cmd_lanes;
    logic [15:0] cmd_next;
    logic        clr_perr;
    logic        clr_tabrt;

    assign cmd_lanes = {{8{~be_n[1]}}, {8{~be_n[0]}}};
    assign cmd_next  = (cmd_q & ~cmd_lanes) | (wdata[15:0] & cmd_lanes);
    assign clr_perr  = wr_hit && !be_n[3] && wdata[16 + ST_PERR_BIT];
    assign clr_tabrt = wr_hit && !be_n[3] && wdata[16 + ST_TABRT_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            perr_q  <= 1'b0;
            tabrt_q <= 1'b0;
        end else begin
            if (wr_hit) begin
                cmd_q <= cmd_next & CMD_WMASK;
            end
            perr_q  <= ev_parity_err   | (perr_q  & ~clr_perr);
            tabrt_q <= ev_target_abort | (tabrt_q & ~clr_tabrt);
        end
    end

    always_comb begin
        rd_val                     = '0;
        rd_val[15:0]               = cmd_q;
        rd_val[16 + ST_PERR_BIT]   = perr_q;
        rd_val[16 + ST_TABRT_BIT]  = tabrt_q;
        rd_val[16 + ST_CAP_BIT]    = HAS_CAP;
    end

    assign io_en  = cmd_q[CMD_IO_BIT];
    assign mem_en = cmd_q[CMD_MEM_BIT];

    logic unused_lanes;
    assign unused_lanes = ^{wdata[30:28], wdata[26:16], be_n[2]};

endmodule

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot
    import cfg_hdr_pkg::*;
#(
    parameter bit PRESENT = 1'b1,
    parameter bit IS_IO   = 1'b0,
    parameter int LOG2    = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_hit,
    input  logic [3:0]  be_n,
    input  logic [31:0] wdata,
    input  logic        space_en,
    input  logic [31:0] bus_addr,
    input  logic        bus_is_io,
    output logic [31:0] rd_val,
    output logic        hit
);
    localparam logic [31:0] AMASK     = size_mask(LOG2);
    localparam logic [31:0] TYPE_BITS = IS_IO ? 32'h0000_0001 : 32'h0000_0000;

    generate
        if (PRESENT) begin : g_live
            logic [31:0] base_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    base_q <= '0;
                end else if (wr_hit) begin
                    base_q <= lane_merge(base_q, wdata, be_n) & AMASK;
                end
            end

            assign rd_val = base_q | TYPE_BITS;
            assign hit    = space_en && (bus_is_io == IS_IO) &&
                            ((bus_addr & AMASK) == base_q);
        end else begin : g_absent
            assign rd_val = '0;
            assign hit    = 1'b0;
            logic unused_slot;
            assign unused_slot = ^{clk, rst, wr_hit, be_n, wdata, space_en,
                                   bus_addr, bus_is_io};
        end
    endgenerate

endmodule

// File: rtl/pci_cfg_header.sv
module pci_cfg_header
    import cfg_hdr_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID   = 16'h1D2C,
    parameter logic [15:0] DEVICE_ID   = 16'h0A51,
    parameter logic [7:0]  REV_ID      = 8'h03,
    parameter logic [23:0] CLASS_CODE  = 24'h118000,
    parameter logic [15:0] SUBSYS_VID  = 16'h1D2C,
    parameter logic [15:0] SUBSYS_ID   = 16'h7001,
    parameter logic [7:0]  INT_PIN     = 8'h01,
    parameter logic [7:0]  MIN_GNT     = 8'h04,
    parameter logic [7:0]  MAX_LAT     = 8'h10,
    parameter logic [7:0]  CAP_PTR     = 8'h40,
    parameter logic [2:0]  BAR_EN      = 3'b011,
    parameter logic [2:0]  BAR_IS_IO   = 3'b010,
    parameter logic [3*LOG2_W-1:0] BAR_LOG2 = {5'd20, 5'd4, 5'd12}
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr,
    input  logic [5:0]  cfg_idx,
    input  logic [3:0]  cfg_be_n,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        ev_parity_err,
    input  logic        ev_target_abort,
    input  logic [31:0] bus_addr,
    input  logic        bus_is_io,
    output logic [NUM_BAR_SLOTS-1:0] bar_hit
);
    localparam bit HAS_CAP = (CAP_PTR != 8'h00);

    cfg_wr_t     wr_s;
    logic [31:0] cs_rd;
    logic        io_en;
    logic        mem_en;
    logic [7:0]  cls_q;
    logic [7:0]  lat_q;
    logic [7:0]  intline_q;
    logic [31:0] bar_rd [NUM_BAR_SLOTS];

    assign wr_s = '{en: cfg_wr, idx: cfg_idx, be_n: cfg_be_n, data: cfg_wdata};

    cfg_cmd_stat #(.HAS_CAP(HAS_CAP)) u_cmd_stat (
        .clk             (clk),
        .rst             (rst),
        .wr_hit          (wr_s.en && wr_s.idx == IDX_CMDSTAT),
        .be_n            (wr_s.be_n),
        .wdata           (wr_s.data),
        .ev_parity_err   (ev_parity_err),
        .ev_target_abort (ev_target_abort),
        .rd_val          (cs_rd),
        .io_en           (io_en),
        .mem_en          (mem_en)
    );

    for (genvar i = 0; i < NUM_BAR_SLOTS; i++) begin : g_bar
        cfg_bar_slot #(
            .PRESENT (BAR_EN[i]),
            .IS_IO   (BAR_IS_IO[i]),
            .LOG2    (int'(BAR_LOG2[LOG2_W*i +: LOG2_W]))
        ) u_slot (
            .clk       (clk),
            .rst       (rst),
            .wr_hit    (wr_s.en && wr_s.idx == IDX_BAR0 + 6'(i)),
            .be_n      (wr_s.be_n),
            .wdata     (wr_s.data),
            .space_en  (BAR_IS_IO[i] ? io_en : mem_en),
            .bus_addr  (bus_addr),
            .bus_is_io (bus_is_io),
            .rd_val    (bar_rd[i]),
            .hit       (bar_hit[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cls_q     <= '0;
            lat_q     <= '0;
            intline_q <= '0;
        end else if (wr_s.en) begin
            if (wr_s.idx == IDX_MISC) begin
                if (!wr_s.be_n[0]) cls_q <= wr_s.data[7:0];
                if (!wr_s.be_n[1]) lat_q <= wr_s.data[15:8];
            end
            if (wr_s.idx == IDX_INTR && !wr_s.be_n[0]) begin
                intline_q <= wr_s.data[7:0];
            end
        end
    end

    always_comb begin
        case (cfg_idx)
            IDX_ID:      cfg_rdata = {DEVICE_ID, VENDOR_ID};
            IDX_CMDSTAT: cfg_rdata = cs_rd;
            IDX_CLASS:   cfg_rdata = {CLASS_CODE, REV_ID};
            IDX_MISC:    cfg_rdata = {16'h0000, lat_q, cls_q};
            IDX_BAR0:    cfg_rdata = bar_rd[0];
            IDX_BAR1:    cfg_rdata = bar_rd[1];
            IDX_BAR2:    cfg_rdata = bar_rd[2];
            IDX_SUBSYS:  cfg_rdata = {SUBSYS_ID, SUBSYS_VID};
            IDX_CAP:     cfg_rdata = {24'h0, CAP_PTR};
            IDX_INTR:    cfg_rdata = {MAX_LAT, MIN_GNT, INT_PIN, intline_q};
            default:     cfg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cfg_header_chk.sv
module cfg_header_chk #(
    parameter logic [2:0] BAR_IS_IO = 3'b010
) (
    input logic        clk,
    input logic        rst,
    input logic        cfg_wr,
    input logic [5:0]  cfg_idx,
    input logic [3:0]  cfg_be_n,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_rdata,
    input logic        ev_parity_err,
    input logic        ev_target_abort,
    input logic        bus_is_io,
    input logic [2:0]  bar_hit,
    input logic        io_en,
    input logic        mem_en,
    input logic [31:0] cs_rd,
    input logic [7:0]  cls_q
);
    assert_unimpl_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (cfg_idx >= 6'd16) |-> (cfg_rdata == 32'h0));

    assert_perr_set_R5: assert property (@(posedge clk) disable iff (rst)
        ev_parity_err |=> cs_rd[31]);

    assert_tabort_set_R5: assert property (@(posedge clk) disable iff (rst)
        ev_target_abort |=> cs_rd[27]);

    assert_perr_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_idx == 6'd1 && !cfg_be_n[3] && cfg_wdata[31] && !ev_parity_err)
        |=> !cs_rd[31]);

    assert_lane_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_idx == 6'd3 && cfg_be_n[0]) |=> $stable(cls_q));

    for (genvar i = 0; i < 3; i++) begin : g_hit
        assert_hit_gate_R9: assert property (@(posedge clk) disable iff (rst)
            bar_hit[i] |-> (BAR_IS_IO[i] ? io_en : mem_en));
        assert_hit_space_R8: assert property (@(posedge clk) disable iff (rst)
            bar_hit[i] |-> (bus_is_io == BAR_IS_IO[i]));
    end

    logic unused_chk;
    assign unused_chk = ^{cfg_wdata[30:0], cfg_be_n[2:0], cs_rd[30:28], cs_rd[26:0]};

endmodule

bind pci_cfg_header cfg_header_chk #(.BAR_IS_IO(BAR_IS_IO)) i_chk (.*);

// File: tb/test_pci_cfg_header.sv
`timescale 1ns/1ps
module test_pci_cfg_header;

    localparam logic [15:0] T_VID   = 16'h1D2C;
    localparam logic [15:0] T_DID   = 16'h0A51;
    localparam logic [7:0]  T_REV   = 8'h03;
    localparam logic [23:0] T_CLASS = 24'h118000;
    localparam logic [15:0] T_SVID  = 16'h1D2C;
    localparam logic [15:0] T_SID   = 16'h7001;
    localparam logic [7:0]  T_IPIN  = 8'h01;
    localparam logic [7:0]  T_MING  = 8'h04;
    localparam logic [7:0]  T_MAXL  = 8'h10;
    localparam logic [7:0]  T_CAP   = 8'h40;
    localparam logic [31:0] M0 = 32'hFFFF_F000;
    localparam logic [31:0] M1 = 32'hFFFF_FFF0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_idx = '0;
    logic [3:0]  cfg_be_n = 4'hF;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        ev_parity_err = 1'b0;
    logic        ev_target_abort = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_is_io = 1'b0;
    logic [2:0]  bar_hit;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    pci_cfg_header #(
        .VENDOR_ID(T_VID), .DEVICE_ID(T_DID), .REV_ID(T_REV), .CLASS_CODE(T_CLASS),
        .SUBSYS_VID(T_SVID), .SUBSYS_ID(T_SID), .INT_PIN(T_IPIN), .MIN_GNT(T_MING),
        .MAX_LAT(T_MAXL), .CAP_PTR(T_CAP), .BAR_EN(3'b011), .BAR_IS_IO(3'b010),
        .BAR_LOG2({5'd20, 5'd4, 5'd12})
    ) i_pci_cfg_header (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] idx, input logic [3:0] be_n, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_idx = idx; cfg_be_n = be_n; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be_n = 4'hF;
    endtask

    task automatic rd_chk(input string req, input logic [5:0] idx, input logic [31:0] exp);
        @(negedge clk);
        cfg_idx = idx;
        #1;
        chk(req, cfg_rdata, exp);
    endtask

    function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                          input logic [3:0] be_n);
        logic [31:0] r;
        for (int k = 0; k < 4; k++) r[8*k +: 8] = be_n[k] ? o[8*k +: 8] : n[8*k +: 8];
        return r;
    endfunction

    function automatic logic [2:0] exp_hit(input logic [31:0] a, input logic io,
                                           input logic [31:0] b0, input logic [31:0] b1,
                                           input logic [15:0] cmd);
        logic [2:0] h;
        h[0] = cmd[1] && !io && ((a & M0) == b0);
        h[1] = cmd[0] &&  io && ((a & M1) == b1);
        h[2] = 1'b0;
        return h;
    endfunction

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] misc_m, intr_m, b0, b1, a;
        logic [15:0] cmd;
        logic        io;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_chk("R1 cmd/status", 6'd1, 32'h0010_0000);
        rd_chk("R1 misc", 6'd3, 32'h0);
        rd_chk("R1 bar0", 6'd4, 32'h0);
        rd_chk("R1 bar1", 6'd5, 32'h1);
        rd_chk("R1 intr", 6'd15, {T_MAXL, T_MING, T_IPIN, 8'h00});
        chk("R1 hits", {29'h0, bar_hit}, 32'h0);

        // R2 identity
        rd_chk("R2 id", 6'd0, {T_DID, T_VID});
        rd_chk("R2 class", 6'd2, {T_CLASS, T_REV});
        rd_chk("R2 subsys", 6'd11, {T_SID, T_SVID});
        rd_chk("R2 cap", 6'd13, {24'h0, T_CAP});
        wr(6'd0, 4'h0, 32'hFFFF_FFFF);
        rd_chk("R2 id ignores write", 6'd0, {T_DID, T_VID});

        // R10 unimplemented
        wr(6'd12, 4'h0, 32'hFFFF_FFFF);
        wr(6'd40, 4'h0, 32'hFFFF_FFFF);
        for (int i = 7; i < 64; i++) begin
            if (i != 11 && i != 13 && i != 15) rd_chk("R10 unimpl", 6'(i), 32'h0);
        end

        // R6/R7 sizing
        wr(6'd4, 4'h0, 32'hFFFF_FFFF);
        rd_chk("R6 mem size", 6'd4, M0);
        wr(6'd5, 4'h0, 32'hFFFF_FFFF);
        rd_chk("R6 io size", 6'd5, M1 | 32'h1);
        wr(6'd6, 4'h0, 32'hFFFF_FFFF);
        rd_chk("R7 absent", 6'd6, 32'h0);

        // R3 byte lanes, R11 next-cycle visibility
        misc_m = 32'h0; intr_m = {T_MAXL, T_MING, T_IPIN, 8'h00};
        for (int i = 0; i < 40; i++) begin
            logic [3:0]  be;
            logic [31:0] d;
            be = 4'($urandom);
            d  = $urandom;
            wr(6'd3, be, d);
            misc_m = merge(misc_m, d, be) & 32'h0000_FFFF;
            rd_chk("R3 misc lanes", 6'd3, misc_m);
            wr(6'd15, be, d);
            intr_m[7:0] = be[0] ? intr_m[7:0] : d[7:0];
            rd_chk("R3 intline lane", 6'd15, intr_m);
        end
        b0 = 32'hFFFF_F000;
        wr(6'd4, 4'b1101, 32'h0000_0000);
        b0 = merge(b0, 32'h0, 4'b1101) & M0;
        rd_chk("R3 bar lane1", 6'd4, b0);

        // R4 command mask
        wr(6'd1, 4'b1100, 32'h0000_FFFF);
        rd_chk("R4 cmd mask", 6'd1, 32'h0010_0147);

        // R5 status flags
        @(negedge clk); ev_parity_err = 1'b1; @(negedge clk); ev_parity_err = 1'b0;
        rd_chk("R5 perr set", 6'd1, 32'h8010_0147);
        @(negedge clk); ev_target_abort = 1'b1; @(negedge clk); ev_target_abort = 1'b0;
        rd_chk("R5 tabort set", 6'd1, 32'h8810_0147);
        wr(6'd1, 4'b0111, 32'h0800_0000);
        rd_chk("R5 clear tabort only", 6'd1, 32'h8010_0147);
        wr(6'd1, 4'b1110, 32'hFFFF_FFFF);
        rd_chk("R5 lane3 off no clear", 6'd1, 32'h8010_0147);
        wr(6'd1, 4'b0111, 32'h7FFF_FFFF);
        rd_chk("R5 zero bit no clear", 6'd1, 32'h8010_0147);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_idx = 6'd1; cfg_be_n = 4'b0111; cfg_wdata = 32'h8000_0000;
        ev_parity_err = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be_n = 4'hF; ev_parity_err = 1'b0;
        rd_chk("R5 event beats clear", 6'd1, 32'h8010_0147);
        wr(6'd1, 4'b0111, 32'h8000_0000);
        rd_chk("R5 perr cleared", 6'd1, 32'h0010_0147);

        // R8 hit decode
        b0 = $urandom & M0;
        b1 = $urandom & M1;
        wr(6'd4, 4'h0, b0);
        wr(6'd5, 4'h0, b1);
        rd_chk("R8 bar0 base", 6'd4, b0);
        rd_chk("R8 bar1 base", 6'd5, b1 | 32'h1);
        cmd = 16'h0147;
        for (int i = 0; i < 80; i++) begin
            int sel;
            sel = int'($urandom % 4);
            case (sel)
                0: begin a = b0 | ($urandom & ~M0); io = 1'b0; end
                1: begin a = b1 | ($urandom & ~M1); io = 1'b1; end
                2: begin a = b0 | ($urandom & ~M0); io = 1'b1; end
                default: begin a = $urandom; io = 1'($urandom); end
            endcase
            @(negedge clk);
            bus_addr = a; bus_is_io = io;
            #1;
            chk("R8 hit", {29'h0, bar_hit}, {29'h0, exp_hit(a, io, b0, b1, cmd)});
        end

        // R9 gating
        wr(6'd1, 4'b1100, 32'h0000_0002);
        cmd = 16'h0002;
        @(negedge clk); bus_addr = b1 | 32'h4; bus_is_io = 1'b1; #1;
        chk("R9 io disabled", {29'h0, bar_hit}, 32'h0);
        @(negedge clk); bus_addr = b0 | 32'h10; bus_is_io = 1'b0; #1;
        chk("R9 mem enabled", {29'h0, bar_hit}, 32'h1);
        wr(6'd1, 4'b1100, 32'h0000_0000);
        #1;
        chk("R9 mem disabled", {29'h0, bar_hit}, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule